// File: doc/BRIEF.md
# Two-Wire Register Bank Slave

This block lets a host on a two-wire serial bus (I2C-compatible) read and write a small bank of 8-bit registers. A faster system clock oversamples SCL and SDA. The block drives SDA only as an open-drain pull-down enable.

A transfer begins with a start condition and a device address byte. The 7-bit device address is fixed except for its lowest bit, which comes from a strap pin. A parameter selects a second address family that sets the top address bit. In a write transfer, the first byte after the address is a register subaddress. Every later byte is stored at the subaddress, which then advances by one. A read transfer streams registers from the current subaddress in the same ascending way. Subaddresses that do not exist are refused. Writes that run past the last register are refused, and reads that run past it repeat the last register. A start or stop that arrives in the middle of a byte abandons the transfer.

A side port shows the contents of any register, one clock after it is selected.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The slave pulls SDA low in the ninth clock slot only after an address byte whose upper seven bits equal {ALT_FAMILY, 1, 0, 1, 0, 1, addr_strap}. With the default family, the write addresses are 0x54 (strap low) and 0x56 (strap high). Every other address is left unacknowledged, and the slave ignores the rest of that transfer.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Bits travel most significant first.
- R3: In a write transfer, the byte after the address loads the subaddress pointer. Each later byte is acknowledged, stored at the pointer, and the pointer is incremented.
- R4: A subaddress byte of NUM_REGS or more is not acknowledged. The slave goes idle, and later bytes of that transfer are neither acknowledged nor stored.
- R5: A write data byte that arrives when the pointer has passed register NUM_REGS-1 is not stored and not acknowledged. The slave goes idle.
- R6: A read transfer returns registers starting at the current pointer, incrementing after each byte the master acknowledges. The pointer survives a stop and a repeated start.
- R7: Once a read has passed register NUM_REGS-1, that register is returned again. A master NACK ends the read, and SDA is then released.
- R8: A start or stop in the middle of any byte returns the slave to waiting for an address, and the partial byte is not stored. A repeated start begins a new address byte.
- R9: The slave changes SDA only just after an SCL falling edge, except that it releases SDA on a start or stop. It never drives SDA during the master's acknowledge slot.
- R10: A synchronous reset clears every register to zero, releases SDA and makes the slave idle.
- R11: reg_data shows the register selected by reg_idx, one clock after reg_idx is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sampled SCL bus line |
| sda_in | input | 1 | Sampled SDA bus line |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_strap | input | 1 | Lowest bit of the 7-bit device address |
| reg_idx | input | $clog2(NUM_REGS) | Register selected for the side port |
| reg_data | output | 8 | Registered contents of the selected register |

## Verification
The bench sweeps all 128 addresses at both strap levels. A comparator that is one bit off, or that ignores the strap, shows up as a wrong acknowledge. It aims at the edges of the register range:
- a subaddress equal to NUM_REGS, where a design that is off by one would acknowledge it;
- a write stream that crosses the top register, where a design that wraps would overwrite register 0;
- a read stream two bytes past the top, where a design that wraps or stops would return wrong data.

Stops and repeated starts are injected partway through a byte. A design that keeps its bit count, or stores the partial byte, then corrupts a register or misses the next address. A monitor also catches SDA changing while SCL is high, which on a real bus would look like a false start or stop.

// File: rtl/i2c_regbank_pkg.sv
package i2c_regbank_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,   // waiting for a start
    ST_ADDR,   // receiving device address byte
    ST_SUB,    // receiving subaddress byte
    ST_WR,     // receiving write data byte
    ST_ACKW,   // byte accepted, wait for SCL fall to drive ACK
    ST_ACK,    // holding ACK low through ninth pulse
    ST_TX,     // shifting a read byte out
    ST_RACKW,  // read byte done, wait for fall to release SDA
    ST_RACK,   // sampling master ACK/NACK
    ST_RNEXT   // master acked, load next byte at SCL fall
  } slv_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // bit 0 = SCL, bit 1 = SDA; two sync flops then a history stage
  logic [1:0] meta, stab, hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= 2'b11;
      stab <= 2'b11;
      hist <= 2'b11;
    end else begin
      meta <= {sda_in, scl_in};
      stab <= meta;
      hist <= stab;
    end
  end

  assign sda_lvl   = stab[1];
  assign scl_rise  = stab[0] & ~hist[0];
  assign scl_fall  = ~stab[0] & hist[0];
  // R2: SDA edge while SCL high on both samples
  assign start_det = stab[0] & hist[0] & hist[1] & ~stab[1];
  assign stop_det  = stab[0] & hist[0] & ~hist[1] & stab[1];
endmodule

// File: rtl/i2c_reg_array.sv
module i2c_reg_array #(
  parameter int NUM_REGS = 8,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] raddr_a,
  output logic [7:0]       rdata_a,
  input  logic [IDX_W-1:0] raddr_b,
  output logic [7:0]       rdata_b
);
  logic [7:0] mem [NUM_REGS];

  // R10: reset clears the whole bank
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= 8'h00;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];

  // R11: registered side port
  always_ff @(posedge clk) begin
    if (rst) rdata_b <= 8'h00;
    else     rdata_b <= mem[raddr_b];
  end
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_regbank_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int IDX_W = $clog2(NUM_REGS),
  localparam int PTR_W = $clog2(NUM_REGS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [6:0]       dev_addr,
  input  logic [7:0]       tx_data,
  output logic [IDX_W-1:0] tx_idx,
  output logic             sda_oe,
  output logic             we,
  output logic [IDX_W-1:0] waddr,
  output logic [7:0]       wdata
);
  slv_state_t       state, after_ack;
  logic [2:0]       cnt;
  logic [6:0]       shreg;
  logic [7:0]       txsh;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       rx_full;
  logic             ptr_past_top;

  assign rx_full      = {shreg, sda_lvl};
  assign ptr_past_top = 32'(ptr) >= NUM_REGS;
  // R7: reads past the top keep addressing the last register
  assign tx_idx = ptr_past_top ? IDX_W'(NUM_REGS - 1) : ptr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    we <= 1'b0;
    if (rst) begin
      state     <= ST_IDLE;
      after_ack <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      txsh      <= '0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
      waddr     <= '0;
      wdata     <= '0;
    end else if (stop_det) begin
      state  <= ST_IDLE;          // R8
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;          // R8: (repeated) start re-enters addressing
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_SUB, ST_WR: if (scl_rise) begin
          shreg <= rx_full[6:0];    // R2: MSB first
          cnt   <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            state <= ST_IDLE;
            if (state == ST_ADDR) begin
              if (rx_full[7:1] == dev_addr) begin   // R1
                state     <= ST_ACKW;
                after_ack <= rx_full[0] ? ST_TX : ST_SUB;
              end
            end else if (state == ST_SUB) begin
              if (32'(rx_full) < NUM_REGS) begin    // R4
                ptr       <= PTR_W'(rx_full);
                state     <= ST_ACKW;
                after_ack <= ST_WR;
              end
            end else if (!ptr_past_top) begin       // R5
              we        <= 1'b1;
              waddr     <= ptr[IDX_W-1:0];
              wdata     <= rx_full;
              ptr       <= ptr + PTR_W'(1);         // R3
              state     <= ST_ACKW;
              after_ack <= ST_WR;
            end
          end
        end
        ST_ACKW: if (scl_fall) begin
          sda_oe <= 1'b1;
          state  <= ST_ACK;
        end
        ST_ACK: if (scl_fall) begin
          cnt <= '0;
          if (after_ack == ST_TX) begin
            txsh   <= tx_data;
            sda_oe <= ~tx_data[7];
          end else begin
            sda_oe <= 1'b0;
          end
          state <= after_ack;
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) state <= ST_RACKW;
          end else if (scl_fall) begin
            txsh   <= {txsh[6:0], 1'b0};
            sda_oe <= ~txsh[6];
          end
        end
        ST_RACKW: if (scl_fall) begin
          sda_oe <= 1'b0;           // R9: master owns the ACK slot
          state  <= ST_RACK;
        end
        ST_RACK: if (scl_rise) begin
          if (sda_lvl) begin
            state <= ST_IDLE;       // R7: NACK ends the read
          end else begin
            if (!ptr_past_top) ptr <= ptr + PTR_W'(1);  // R6
            state <= ST_RNEXT;
          end
        end
        ST_RNEXT: if (scl_fall) begin
          txsh   <= tx_data;
          sda_oe <= ~tx_data[7];
          cnt    <= '0;
          state  <= ST_TX;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter int NUM_REGS = 8,
  parameter bit ALT_FAMILY = 1'b0,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_oe,
  input  logic             addr_strap,
  input  logic [IDX_W-1:0] reg_idx,
  output logic [7:0]       reg_data
);
  logic             sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic             we;
  logic [IDX_W-1:0] waddr, tx_idx;
  logic [7:0]       wdata, tx_data;
  logic [6:0]       dev_addr;

  assign dev_addr = {ALT_FAMILY, 5'b10101, addr_strap};

  i2c_line_sync u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_slave_fsm #(.NUM_REGS(NUM_REGS)) u_fsm (
    .clk(clk), .rst(rst), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .dev_addr(dev_addr), .tx_data(tx_data), .tx_idx(tx_idx),
    .sda_oe(sda_oe), .we(we), .waddr(waddr), .wdata(wdata)
  );

  i2c_reg_array #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr_a(tx_idx), .rdata_a(tx_data),
    .raddr_b(reg_idx), .rdata_b(reg_data)
  );
endmodule

// File: rtl/i2c_regbank_slave_chk.sv
module i2c_regbank_slave_chk (
  input logic clk,
  input logic rst,
  input logic sda_oe,
  input logic scl_fall,
  input logic start_det,
  input logic stop_det,
  input logic we
);
  // R9: the SDA enable only moves right after an SCL fall, or on start/stop
  a_r9_sda_moves_after_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

  // R8: a stop always leaves SDA released
  a_r8_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R8: a start always leaves SDA released
  a_r8_start_releases: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_oe);

  // R10: the cycle after reset, SDA is released and nothing is written
  a_r10_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (!sda_oe && !we));

  // R3: a register write is only issued when a byte completes on an SCL rise,
  // never on the cycle a start or stop is seen
  a_r3_write_not_on_startstop: assert property (@(posedge clk) disable iff (rst)
    we |-> !$past(start_det) && !$past(stop_det));
endmodule

bind i2c_regbank_slave i2c_regbank_slave_chk u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .we(we)
);

// File: tb/i2c_regbank_slave_test.sv
module i2c_regbank_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;
  localparam int Q = 4;   // clocks per quarter SCL period

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       strap = 1'b0;
  logic [2:0] idx = '0;
  logic [7:0] rdata;
  logic       sda_oe;
  wire        sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  int hi_moves = 0;
  bit done = 1'b0;
  logic [7:0] model [NREG];

  i2c_regbank_slave #(.NUM_REGS(NREG), .ALT_FAMILY(1'b0)) uut (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_bus), .sda_oe(sda_oe),
    .addr_strap(strap), .reg_idx(idx), .reg_data(rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // R9 monitor: SDA enable must not move while the SCL line is high
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (!rst && scl && sda_oe !== prev_oe) hi_moves++;
    prev_oe <= sda_oe;
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_start;
    sda_m = 1'b1; wclk(Q);
    scl = 1'b1;   wclk(Q);
    sda_m = 1'b0; wclk(Q);
    scl = 1'b0;   wclk(Q);
  endtask

  task automatic m_stop;
    sda_m = 1'b0; wclk(Q);
    scl = 1'b1;   wclk(Q);
    sda_m = 1'b1; wclk(Q);
  endtask

  task automatic m_bit(input logic b);
    sda_m = b;  wclk(Q);
    scl = 1'b1; wclk(2*Q);
    scl = 1'b0; wclk(Q);
  endtask

  task automatic m_rd_bit(output logic b);
    sda_m = 1'b1; wclk(Q);
    scl = 1'b1;   wclk(Q);
    b = sda_bus;  wclk(Q);
    scl = 1'b0;   wclk(Q);
  endtask

  task automatic m_write(input logic [7:0] v, output logic ack);
    logic nb;
    for (int i = 7; i >= 0; i--) m_bit(v[i]);
    m_rd_bit(nb);
    ack = ~nb;
  endtask

  task automatic m_read(input logic ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) m_rd_bit(v[i]);
    sda_m = ~ack; wclk(Q);
    scl = 1'b1;   wclk(Q);
    check_eq("R9 slave released in master ack slot", int'(sda_oe), 0);
    wclk(Q);
    scl = 1'b0;   wclk(Q);
  endtask

  task automatic peek(input int i, output logic [7:0] v);
    idx = 3'(i);
    wclk(2);
    v = rdata;
  endtask

  task automatic check_bank(input string req);
    logic [7:0] v;
    for (int i = 0; i < NREG; i++) begin
      peek(i, v);
      check_eq(req, int'(v), int'(model[i]));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] v;
    logic [7:0] wa, ra;

    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    wclk(4);
    rst = 1'b0;
    wclk(2);
    check_eq("R10 sda released after reset", int'(sda_oe), 0);
    check_bank("R10 R11 bank zero after reset");

    // R1: sweep every 7-bit address at both strap levels
    for (int s = 0; s < 2; s++) begin
      strap = 1'(s);
      wclk(2);
      for (int a = 0; a < 128; a++) begin
        m_start;
        m_write(8'(a << 1), ack);
        check_eq($sformatf("R1 ack for addr %0h strap %0d", a, s),
                 int'(ack), (a == (8'h2A | s)) ? 1 : 0);
        m_stop;
      end
    end
    check_bank("R1 sweep wrote nothing");

    strap = 1'b1;
    wa = 8'h56;
    ra = 8'h57;

    // R3 / R2: fill the bank from subaddress 0
    m_start;
    m_write(wa, ack); check_eq("R1 write address acked", int'(ack), 1);
    m_write(8'h00, ack); check_eq("R3 subaddress 0 acked", int'(ack), 1);
    for (int i = 0; i < NREG; i++) begin
      model[i] = 8'((i * 29 + 7) ^ (i == 0 ? 8'h80 : 8'h00));
      m_write(model[i], ack);
      check_eq("R3 data byte acked", int'(ack), 1);
    end
    m_stop;
    check_bank("R2 R3 R11 bank after sequential write");

    // R6 / R7: read stream from 0, two bytes past the top
    m_start;
    m_write(wa, ack);
    m_write(8'h00, ack);
    m_start;
    m_write(ra, ack); check_eq("R6 read address acked", int'(ack), 1);
    for (int i = 0; i < NREG + 2; i++) begin
      m_read(i != NREG + 1, v);
      check_eq($sformatf("R6 R7 read byte %0d", i), int'(v),
               int'(model[(i < NREG) ? i : NREG - 1]));
    end
    m_stop;
    wclk(2);
    check_eq("R7 sda released after master NACK", int'(sda_oe), 0);

    // R6: pointer retained across repeated start
    m_start;
    m_write(wa, ack);
    m_write(8'h05, ack);
    m_start;
    m_write(ra, ack);
    m_read(1'b1, v); check_eq("R6 retained pointer first byte", int'(v), int'(model[5]));
    m_read(1'b0, v); check_eq("R6 retained pointer second byte", int'(v), int'(model[6]));
    m_stop;

    // R6: pointer kept after a stop following a write
    m_start;
    m_write(wa, ack);
    m_write(8'h02, ack);
    model[2] = 8'hC3;
    m_write(8'hC3, ack);
    m_stop;
    m_start;
    m_write(ra, ack);
    m_read(1'b0, v); check_eq("R6 read continues after stop", int'(v), int'(model[3]));
    m_stop;

    // R4: invalid subaddresses
    m_start;
    m_write(wa, ack);
    m_write(8'(NREG), ack); check_eq("R4 subaddress NUM_REGS refused", int'(ack), 0);
    m_write(8'hEE, ack);    check_eq("R4 later byte ignored", int'(ack), 0);
    m_stop;
    m_start;
    m_write(wa, ack);
    m_write(8'hFF, ack); check_eq("R4 subaddress FF refused", int'(ack), 0);
    m_stop;
    check_bank("R4 bank unchanged");

    // R5: write running past the top register
    m_start;
    m_write(wa, ack);
    m_write(8'(NREG - 2), ack);
    model[NREG-2] = 8'h11; m_write(8'h11, ack); check_eq("R5 byte at top-1 acked", int'(ack), 1);
    model[NREG-1] = 8'h22; m_write(8'h22, ack); check_eq("R5 byte at top acked", int'(ack), 1);
    m_write(8'h33, ack); check_eq("R5 byte past top refused", int'(ack), 0);
    m_write(8'h44, ack); check_eq("R5 slave idle after overrun", int'(ack), 0);
    m_stop;
    check_bank("R5 overrun bytes discarded");

    // R8: stop in the middle of a data byte
    m_start;
    m_write(wa, ack);
    m_write(8'h01, ack);
    for (int i = 0; i < 4; i++) m_bit(1'b1);
    m_stop;
    check_bank("R8 partial byte after stop not stored");

    // R8: repeated start in the middle of a data byte
    m_start;
    m_write(wa, ack);
    m_write(8'h04, ack);
    for (int i = 0; i < 3; i++) m_bit(1'b0);
    m_start;
    m_write(wa, ack); check_eq("R8 address after mid-byte start acked", int'(ack), 1);
    m_write(8'h06, ack); check_eq("R8 subaddress after restart acked", int'(ack), 1);
    model[6] = 8'h5A;
    m_write(8'h5A, ack); check_eq("R8 data after restart acked", int'(ack), 1);
    m_stop;
    check_bank("R8 bank after mid-byte restart");

    // R8: start in the middle of the address byte
    m_start;
    for (int i = 0; i < 5; i++) m_bit(1'b1);
    m_start;
    m_write(ra, ack); check_eq("R8 address after aborted address acked", int'(ack), 1);
    m_read(1'b0, v); check_eq("R8 R6 read after abort", int'(v), int'(model[7]));
    m_stop;

    check_eq("R9 sda moves while SCL high", hi_moves, 0);

    // R10: reset in the middle of operation clears the bank
    wclk(2);
    rst = 1'b1;
    wclk(2);
    rst = 1'b0;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    wclk(2);
    check_eq("R10 sda released after second reset", int'(sda_oe), 0);
    check_bank("R10 bank cleared by reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule